// File: doc/BRIEF.md
# Memory Request Splitter and Address Decoder

This block sits between an application port and the bank controller of an SDRAM controller. The application presents a transfer request. The request carries a word address, a length in 32-bit application words, a direction and a wrap flag. The block first converts the word address and the length into memory beats for the configured memory data width. For a plain (non-wrapping) request, it then cuts the beat range into pieces. No piece runs past the end of a column page. Each piece is decoded into bank, row and column fields. The split depends on the column-width code set at run time.

The pieces go to the bank controller one at a time over a request/acknowledge handshake. Start and last flags mark the first and the final piece of the original request. A wrapping request is not split. It is forwarded as one fixed 4-beat wrapping transfer. The application holds its request until the block returns a one-cycle acknowledge, which marks the moment the final piece is taken. A busy-not output tells the application when a new request may be presented. It stays low until memory initialisation has finished.

Top module: `req_splitter`

## Requirements
- R1: While `init_done` is low, `busy_n` is low and no request is accepted (`bk_req` stays low even with `req_valid` high).
- R2: `busy_n` is low from the cycle after a request is captured until the final piece is acknowledged, and is high again in the following cycle.
- R3: The column code selects the column width as 8 + code bits (00=8, 01=9, 10=10, 11=11). `bk_col` is the low column-width bits of the beat address. `bk_bank` is the next 2 bits above them. `bk_row` is the 12 bits above the bank bits.
- R4: The width code selects the memory width: 00 is 32-bit (shift 0), 01 is 16-bit (shift 1), and 10 or 11 is 8-bit (shift 2). The beat address is the word address shifted left by that amount, and the beat length is the word length shifted by the same amount.
- R5: For a non-wrapping request, each piece's length is the smaller of the remaining beats and the beats left to the end of the current page, so that `bk_col + bk_len` never exceeds the page size.
- R6: The pieces of a non-wrapping request are contiguous in beat address, and their lengths add up to the scaled request length.
- R7: `bk_start` is high on the first piece only. `bk_last` is high on the final piece only.
- R8: A wrapping request produces one piece with length 4, with start, last and `bk_wrap` all high, at the unmodified decoded start column.
- R9: While `bk_req` is high and `bk_ack` is low, all piece fields stay unchanged.
- R10: `req_ack` is high for exactly one cycle, the cycle in which the final piece is acknowledged, and is low at all other times.
- R11: `bk_write` equals the captured request direction on every piece.
- R12: After reset, `bk_req` and `req_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Memory initialisation finished |
| width_mode | input | 2 | Memory data width code (quasi-static) |
| col_code | input | 2 | Column width code (quasi-static) |
| req_valid | input | 1 | Application request present, held until `req_ack` |
| req_addr | input | ADDR_W | Word address |
| req_len | input | LEN_W | Length in 32-bit words |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wrap | input | 1 | Wrapping 4-beat transfer |
| req_ack | output | 1 | Final piece accepted |
| busy_n | output | 1 | High when a new request may be presented |
| bk_req | output | 1 | Piece valid toward bank controller |
| bk_start | output | 1 | First piece of the request |
| bk_last | output | 1 | Final piece of the request |
| bk_wrap | output | 1 | Piece is a wrapping transfer |
| bk_write | output | 1 | Piece direction |
| bk_bank | output | 2 | Decoded bank |
| bk_row | output | 12 | Decoded row |
| bk_col | output | 12 | Decoded column |
| bk_len | output | LEN_W+3 | Piece length in beats |
| bk_ack | input | 1 | Bank controller takes the piece |

## Verification
Some properties are checked on every cycle:
- the page bound on each plain piece;
- the 4-beat shape of wrap pieces;
- holding of fields under back-pressure;
- the one-cycle acknowledge;
- the busy indication before initialisation and during a transfer;
- the loss of the start flag after a piece is taken.

Other properties only the directed scenarios can show. These are the exact bank, row and column bit positions for each column code and width code, the piece lengths across one or more page crossings, the contiguity and total length of the pieces, and the direction passing through.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 12;
    localparam int WRAP_BEATS = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } split_st_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } mem_loc_t;

    // Beat shift for the memory width code: 32-bit, 16-bit, 8-bit.
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        logic [1:0] s;
        case (code)
            2'b00:   s = 2'd0;
            2'b01:   s = 2'd1;
            default: s = 2'd2;
        endcase
        return s;
    endfunction

    // Number of column bits for the column code.
    function automatic logic [3:0] col_bits(input logic [1:0] code);
        return 4'd8 + {2'b00, code};
    endfunction

endpackage

// File: rtl/rsplit_decode.sv
module rsplit_decode
    import rsplit_pkg::*;
#(
    parameter int BEAT_W = 28,
    parameter int PL_W   = 12
) (
    input  logic [BEAT_W-1:0] beat_addr,
    input  logic [1:0]        col_code,
    output mem_loc_t          loc,
    output logic [PL_W-1:0]   to_page_end
);
    logic [3:0]        cb;
    logic [BEAT_W-1:0] low_mask;
    logic [BEAT_W-1:0] col_full;

    always_comb begin
        cb          = col_bits(col_code);
        low_mask    = (BEAT_W'(1) << cb) - BEAT_W'(1);
        col_full    = beat_addr & low_mask;
        loc.col     = COL_W'(col_full);
        loc.bank    = BANK_W'(beat_addr >> cb);
        loc.row     = ROW_W'(beat_addr >> (cb + 4'd2));
        to_page_end = (PL_W'(1) << cb) - PL_W'(loc.col);
    end

endmodule

// File: rtl/rsplit_piece.sv
module rsplit_piece
    import rsplit_pkg::*;
#(
    parameter int PL_W = 12
) (
    input  logic [PL_W-1:0] remain,
    input  logic [PL_W-1:0] to_page_end,
    input  logic            wrap,
    output logic [PL_W-1:0] piece_len,
    output logic            piece_last
);
    always_comb begin
        if (wrap) begin
            piece_len  = PL_W'(WRAP_BEATS);
            piece_last = 1'b1;
        end else if (remain <= to_page_end) begin
            piece_len  = remain;
            piece_last = 1'b1;
        end else begin
            piece_len  = to_page_end;
            piece_last = 1'b0;
        end
    end

endmodule

// File: rtl/rsplit_ctrl.sv
module rsplit_ctrl
    import rsplit_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 9,
    parameter int BEAT_W = ADDR_W + 2,
    parameter int PL_W   = LEN_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_done,
    input  logic [1:0]        width_mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              req_wrap,
    input  logic              bk_ack,
    input  logic [PL_W-1:0]   piece_len,
    input  logic              piece_last,
    output logic              busy_n,
    output logic              bk_req,
    output logic              bk_start,
    output logic              req_ack,
    output logic [BEAT_W-1:0] cur_beat,
    output logic [PL_W-1:0]   remain,
    output logic              wrap_q,
    output logic              write_q
);
    split_st_t st;
    logic      first_q;
    logic      take;
    logic      accept;
    logic [1:0] sh;

    assign sh     = width_shift(width_mode);
    assign take   = (st == ST_IDLE) && init_done && req_valid;
    assign accept = (st == ST_SEND) && bk_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            first_q  <= 1'b0;
            cur_beat <= '0;
            remain   <= '0;
            wrap_q   <= 1'b0;
            write_q  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (take) begin
                        st       <= ST_SEND;
                        first_q  <= 1'b1;
                        cur_beat <= BEAT_W'(req_addr) << sh;
                        remain   <= PL_W'(req_len) << sh;
                        wrap_q   <= req_wrap;
                        write_q  <= req_write;
                    end
                end
                ST_SEND: begin
                    if (accept) begin
                        first_q <= 1'b0;
                        if (piece_last) begin
                            st <= ST_IDLE;
                        end else begin
                            cur_beat <= cur_beat + BEAT_W'(piece_len);
                            remain   <= remain - piece_len;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bk_req   = (st == ST_SEND);
    assign bk_start = first_q;
    assign req_ack  = accept && piece_last;
    assign busy_n   = (st == ST_IDLE) && init_done;

    // R1: nothing may be arbitrated before initialisation.
    a_r1_no_accept_uninit: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !busy_n);

    // R2: busy while a piece is outstanding.
    a_r2_busy_in_flight: assert property (@(posedge clk) disable iff (rst)
        bk_req |-> !busy_n);

    // R10: acknowledge lasts one cycle.
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    // R7: after a non-final piece is taken the next one is not a start.
    a_r7_start_once: assert property (@(posedge clk) disable iff (rst)
        (bk_req && bk_ack && !piece_last) |=> (bk_req && !bk_start));

endmodule

// File: rtl/req_splitter.sv
module req_splitter
    import rsplit_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_done,
    input  logic [1:0]        width_mode,
    input  logic [1:0]        col_code,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              req_wrap,
    output logic              req_ack,
    output logic              busy_n,
    output logic              bk_req,
    output logic              bk_start,
    output logic              bk_last,
    output logic              bk_wrap,
    output logic              bk_write,
    output logic [1:0]        bk_bank,
    output logic [11:0]       bk_row,
    output logic [11:0]       bk_col,
    output logic [LEN_W+2:0]  bk_len,
    input  logic              bk_ack
);
    localparam int BEAT_W = ADDR_W + 2;
    localparam int PL_W   = LEN_W + 3;

    logic [BEAT_W-1:0] cur_beat;
    logic [PL_W-1:0]   remain;
    logic [PL_W-1:0]   to_end;
    logic [PL_W-1:0]   piece_len;
    logic              piece_last;
    logic              wrap_q;
    logic              write_q;
    mem_loc_t          loc;

    rsplit_decode #(.BEAT_W(BEAT_W), .PL_W(PL_W)) u_decode (
        .beat_addr   (cur_beat),
        .col_code    (col_code),
        .loc         (loc),
        .to_page_end (to_end)
    );

    rsplit_piece #(.PL_W(PL_W)) u_piece (
        .remain      (remain),
        .to_page_end (to_end),
        .wrap        (wrap_q),
        .piece_len   (piece_len),
        .piece_last  (piece_last)
    );

    rsplit_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_W(BEAT_W), .PL_W(PL_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .init_done  (init_done),
        .width_mode (width_mode),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_write  (req_write),
        .req_wrap   (req_wrap),
        .bk_ack     (bk_ack),
        .piece_len  (piece_len),
        .piece_last (piece_last),
        .busy_n     (busy_n),
        .bk_req     (bk_req),
        .bk_start   (bk_start),
        .req_ack    (req_ack),
        .cur_beat   (cur_beat),
        .remain     (remain),
        .wrap_q     (wrap_q),
        .write_q    (write_q)
    );

    assign bk_last  = piece_last;
    assign bk_wrap  = wrap_q;
    assign bk_write = write_q;
    assign bk_bank  = loc.bank;
    assign bk_row   = loc.row;
    assign bk_col   = loc.col;
    assign bk_len   = piece_len;

    // R5: a plain piece stays inside its page.
    a_r5_page_bound: assert property (@(posedge clk) disable iff (rst)
        (bk_req && !bk_wrap) |->
            ((int'(bk_col) + int'(bk_len)) <= (1 << (8 + int'(col_code)))));

    // R8: wrap pieces are single 4-beat transfers.
    a_r8_wrap_shape: assert property (@(posedge clk) disable iff (rst)
        (bk_req && bk_wrap) |-> (bk_len == (LEN_W+3)'(WRAP_BEATS) && bk_start && bk_last));

    // R9: fields hold while the bank controller stalls.
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (bk_req && !bk_ack) |=> (bk_req && $stable(bk_col) && $stable(bk_row)
            && $stable(bk_bank) && $stable(bk_len) && $stable(bk_start)));

endmodule

// File: tb/sim_req_splitter.sv
module sim_req_splitter;
    localparam int AW = 26;
    localparam int LW = 9;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, init_done, req_valid, req_write, req_wrap, bk_ack;
    logic [1:0] width_mode, col_code;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic req_ack, busy_n, bk_req, bk_start, bk_last, bk_wrap, bk_write;
    logic [1:0] bk_bank;
    logic [11:0] bk_row, bk_col;
    logic [LW+2:0] bk_len;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    req_splitter #(.ADDR_W(AW), .LEN_W(LW)) u0 (
        .clk(clk), .rst(rst), .init_done(init_done), .width_mode(width_mode),
        .col_code(col_code), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_wrap(req_wrap),
        .req_ack(req_ack), .busy_n(busy_n), .bk_req(bk_req), .bk_start(bk_start),
        .bk_last(bk_last), .bk_wrap(bk_wrap), .bk_write(bk_write),
        .bk_bank(bk_bank), .bk_row(bk_row), .bk_col(bk_col), .bk_len(bk_len),
        .bk_ack(bk_ack)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Drives one request and plays the bank controller, checking every piece.
    task automatic run_req(input string tag, input longint addr, input int len,
                           input bit wr, input bit wrap, input bit [1:0] wm,
                           input bit [1:0] cc, input int stall);
        int sh = (wm == 2'b00) ? 0 : ((wm == 2'b01) ? 1 : 2);
        int cb = 8 + int'(cc);
        longint page = longint'(1) << cb;
        longint beat = addr << sh;
        longint rem = longint'(len) << sh;
        longint sum = 0;
        int npiece = 0;
        bit done = 0;
        @(negedge clk);
        width_mode = wm; col_code = cc; req_addr = AW'(addr);
        req_len = LW'(len); req_write = wr; req_wrap = wrap; req_valid = 1'b1;
        chk(busy_n == 1'b1, {tag, " R2 free before request"}, busy_n, 1);
        @(negedge clk);
        while (!done) begin
            longint col = beat % page;
            longint te = page - col;
            longint p;
            bit last;
            longint bank = (beat >> cb) & 3;
            longint row = (beat >> (cb + 2)) & 12'hfff;
            if (wrap) begin p = 4; last = 1; end
            else if (rem <= te) begin p = rem; last = 1; end
            else begin p = te; last = 0; end
            chk(bk_req == 1'b1, {tag, " R2 piece offered"}, bk_req, 1);
            chk(busy_n == 1'b0, {tag, " R2 busy during transfer"}, busy_n, 0);
            chk(bk_col == 12'(col), {tag, " R3 column"}, bk_col, col);
            chk(bk_bank == 2'(bank), {tag, " R3 bank"}, bk_bank, bank);
            chk(bk_row == 12'(row), {tag, " R3 R4 row"}, bk_row, row);
            chk(longint'(bk_len) == p, {tag, " R5 piece length"}, bk_len, p);
            chk(bk_start == (npiece == 0), {tag, " R7 start flag"}, bk_start, npiece == 0);
            chk(bk_last == last, {tag, " R7 last flag"}, bk_last, last);
            chk(bk_wrap == wrap, {tag, " R8 wrap flag"}, bk_wrap, wrap);
            chk(bk_write == wr, {tag, " R11 direction"}, bk_write, wr);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(bk_req && bk_col == 12'(col) && longint'(bk_len) == p
                    && bk_start == (npiece == 0), {tag, " R9 held under stall"}, bk_col, col);
                chk(req_ack == 1'b0, {tag, " R10 no ack while stalled"}, req_ack, 0);
            end
            bk_ack = 1'b1;
            #1;
            chk(req_ack == last, {tag, " R10 ack on final piece"}, req_ack, last);
            @(posedge clk);
            #1;
            bk_ack = 1'b0;
            if (last) req_valid = 1'b0;
            sum += p; beat += p; rem -= p; npiece++;
            done = last;
            @(negedge clk);
        end
        chk(req_ack == 1'b0, {tag, " R10 ack is one cycle"}, req_ack, 0);
        if (!wrap)
            chk(sum == (longint'(len) << sh), {tag, " R6 R4 total beats"}, sum, longint'(len) << sh);
        else
            chk(npiece == 1, {tag, " R8 single piece"}, npiece, 1);
        chk(busy_n == 1'b1 && bk_req == 1'b0, {tag, " R2 released"}, busy_n, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1; init_done = 1'b0; req_valid = 1'b0; bk_ack = 1'b0;
        req_write = 1'b0; req_wrap = 1'b0; width_mode = 2'b00; col_code = 2'b00;
        req_addr = '0; req_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bk_req == 1'b0, "R12 reset piece valid", bk_req, 0);
        chk(req_ack == 1'b0, "R12 reset ack", req_ack, 0);
        chk(busy_n == 1'b0, "R1 busy before init", busy_n, 0);
    endtask

    task automatic t_uninit();
        req_addr = AW'(26'h100); req_len = LW'(3); req_valid = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(bk_req == 1'b0, "R1 no acceptance before init", bk_req, 0);
            chk(busy_n == 1'b0, "R1 busy_n low before init", busy_n, 0);
        end
        req_valid = 1'b0;
        init_done = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R1 free after init", busy_n, 1);
        chk(bk_req == 1'b0, "R1 no stale request", bk_req, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        t_reset();
        t_uninit();
        run_req("single",    64'h12345, 10,  0, 0, 2'b00, 2'b00, 0);
        run_req("cross",     64'h000FA, 20,  1, 0, 2'b00, 2'b00, 0);
        run_req("w16",       64'h001F0, 300, 0, 0, 2'b01, 2'b01, 0);
        run_req("w8",        64'h3FF0F, 511, 1, 0, 2'b10, 2'b10, 0);
        run_req("w8alt",     64'h0ABCD, 2,   0, 0, 2'b11, 2'b00, 0);
        run_req("col11",     64'h007F0, 400, 0, 0, 2'b00, 2'b11, 0);
        run_req("wrap",      64'h000FE, 10,  1, 1, 2'b00, 2'b00, 0);
        run_req("wrap16",    64'h2C3F7, 1,   0, 1, 2'b01, 2'b10, 2);
        run_req("stall",     64'h1F0FC, 9,   1, 0, 2'b00, 2'b00, 3);
        run_req("backtoback",64'h1F104, 5,   0, 0, 2'b00, 2'b00, 0);
        finish_run();
    end

endmodule